// File: doc/BRIEF.md
# Interrupt Entry and Vector Sequencer

This block recognises interrupts for a small 16-bit x86-style core and carries out the entry into the service routine. The core pulses `boundary` when an instruction retires. In that cycle it also presents the flags image, the current CS and IP, and the events raised by the retiring instruction. If any source is pending, the block chooses exactly one of them. It then holds the chosen type and its vector-table base address on its outputs for the whole entry.

The entry always runs in the same order:
1. Push FLAGS, then CS, then IP, through a request/acknowledge stack port.
2. Pulse a flag-clear strobe, which tells the core to clear TF and IF. This strobe comes only after the FLAGS push has been accepted, so the saved image still carries the old TF.
3. Read the new IP word and then the new CS word from the vector table, through a second request/acknowledge port.

When the entry finishes, the loaded CS:IP is presented together with a one-cycle `done` pulse.

The external nonmaskable line is edge-sensitive. It is synchronised, its rising edge is latched, and it is serviced at the next boundary. While a nonmaskable entry is in progress, a DMA-suspend output is held high.

Top module: `int_entry_seq`

## Requirements
- R1: The vector base is the type times four, zero-extended to 20 bits. Examples: type 21h gives 00084h and type FFh gives 003FCh. The new IP word is read at the base and the new CS word at base+2.
- R2: When several sources are pending at a boundary, the priority from highest to lowest is:
  - trace (01h)
  - divide error (00h)
  - INT3 (03h)
  - INTO with OF set (04h)
  - software INT n (type from `swint_type`)
  - NMI (02h)
  - maskable request (type from `hw_type`)
- R3: A trace interrupt is raised at a boundary when `tf_in` is 1 and none of `last_prefix`, `last_segload` or `last_wait` is 1. If any of those three is 1, no trace is raised.
- R4: INTO raises type 04h only when `of_in` is 1. With OF clear, INTO has no effect and lower sources are considered. Software INT n accepts all 256 types.
- R5: A maskable request is ignored while `if_in` is 0: `busy` stays 0 and no stack request appears.
- R6: A rising edge on `nmi_pin` is synchronised and latched. A high level lasting one clock period is enough. The latched request is taken at the next boundary. A level that stays high does not trigger again.
- R7: The NMI latch clears when NMI entry starts. A new rising edge that arrives during the entry is kept and taken at a later boundary.
- R8: Entry pushes FLAGS, then CS, then IP, and then reads the vector IP word and then the CS word. Each step holds its request, data and address until it is acknowledged. The stack and vector requests are never high together.
- R9: The FLAGS value pushed is the `flags_in` image captured at the boundary, with TF unchanged. `flag_clr` pulses exactly once per entry, in the cycle after the FLAGS push is acknowledged.
- R10: `dma_suspend` is 1 throughout an NMI entry and 0 at all other times.
- R11: After the CS word is acknowledged:
  - `new_ip` and `new_cs` hold the two fetched words;
  - `done` pulses for one cycle;
  - `busy` returns to 0.
  Boundaries that arrive while `busy` is 1 are ignored.
- R12: After reset, `busy`, `push_req`, `vec_req`, `dma_suspend`, `flag_clr` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| last_prefix | input | 1 | Retired instruction was a prefix |
| last_segload | input | 1 | Retired instruction loaded a segment register |
| last_wait | input | 1 | Retired instruction was WAIT |
| tf_in | input | 1 | Current trace flag |
| if_in | input | 1 | Current interrupt-enable flag |
| of_in | input | 1 | Current overflow flag |
| div_err | input | 1 | Divide quotient overflow |
| swint_req | input | 1 | Software INT n executed |
| swint_type | input | 8 | Type operand of INT n |
| int3_req | input | 1 | Breakpoint instruction executed |
| into_req | input | 1 | INTO executed |
| hw_req | input | 1 | Maskable request pending |
| hw_type | input | 8 | Type of maskable request |
| nmi_pin | input | 1 | Nonmaskable request line |
| flags_in | input | 16 | FLAGS image at boundary |
| cs_in | input | 16 | CS at boundary |
| ip_in | input | 16 | Return IP at boundary |
| push_req | output | 1 | Stack push request |
| push_data | output | 16 | Word to push |
| push_ack | input | 1 | Push accepted |
| vec_req | output | 1 | Vector word read request |
| vec_addr | output | 20 | Vector word address |
| vec_ack | input | 1 | Read complete, data valid |
| vec_data | input | 16 | Vector word read |
| busy | output | 1 | Entry in progress |
| int_type | output | 8 | Chosen interrupt type |
| vec_base | output | 20 | Vector base of chosen type |
| flag_clr | output | 1 | Clear TF and IF strobe |
| dma_suspend | output | 1 | DMA suspend during NMI entry |
| done | output | 1 | Entry complete pulse |
| new_cs | output | 16 | Loaded code segment |
| new_ip | output | 16 | Loaded instruction pointer |

## Verification
Some properties are checked by assertions on every cycle:
- the two request ports are never high together;
- requests stay stable while they are stalled;
- vector addresses line up with the chosen type;
- `dma_suspend` is tied to an NMI entry;
- `flag_clr` follows an accepted push;
- `done` follows an accepted vector read;
- outputs are quiet when idle.

Other behaviour can only be shown by the bench's scenarios: the priority order, trace suppression after prefixes, segment loads and WAIT, masking by IF, INTO gating by OF, and the NMI edge latch with its re-capture during entry. The pushed values, the fetched CS:IP and the vector base are swept over all 256 software and all 256 maskable types.

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          last_prefix,
  input  logic          last_segload,
  input  logic          last_wait,
  input  logic          tf_in,
  input  logic          if_in,
  input  logic          of_in,
  input  logic          div_err,
  input  logic          swint_req,
  input  logic [TW-1:0] swint_type,
  input  logic          int3_req,
  input  logic          into_req,
  input  logic          hw_req,
  input  logic [TW-1:0] hw_type,
  input  logic          nmi_pin,
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] ip_in,
  output logic          push_req,
  output logic [DW-1:0] push_data,
  input  logic          push_ack,
  output logic          vec_req,
  output logic [AW-1:0] vec_addr,
  input  logic          vec_ack,
  input  logic [DW-1:0] vec_data,
  output logic          busy,
  output logic [TW-1:0] int_type,
  output logic [AW-1:0] vec_base,
  output logic          flag_clr,
  output logic          dma_suspend,
  output logic          done,
  output logic [DW-1:0] new_cs,
  output logic [DW-1:0] new_ip
);
  localparam int PADW = AW - TW - 2;
  localparam logic [TW-1:0] T_DIV   = TW'(8'h00);
  localparam logic [TW-1:0] T_TRACE = TW'(8'h01);
  localparam logic [TW-1:0] T_NMI   = TW'(8'h02);
  localparam logic [TW-1:0] T_BRK   = TW'(8'h03);
  localparam logic [TW-1:0] T_OVF   = TW'(8'h04);

  typedef enum logic [2:0] {S_IDLE, S_PF, S_PC, S_PI, S_VI, S_VC} state_t;
  state_t st;

  logic [TW-1:0] type_q, sel_type;
  logic [DW-1:0] sv_flags, sv_cs, sv_ip, ip_tmp;
  logic          sel_nmi, any_src, hit;
  logic          nmi_s1, nmi_s2, nmi_s3, nmi_pend;
  logic          dma_q;

  wire trace_ok = tf_in & ~(last_prefix | last_segload | last_wait);
  wire ovf_ok   = into_req & of_in;
  wire hw_ok    = hw_req & if_in;

  always_comb begin
    sel_type = '0;
    sel_nmi  = 1'b0;
    any_src  = 1'b1;
    if (trace_ok)       sel_type = T_TRACE;
    else if (div_err)   sel_type = T_DIV;
    else if (int3_req)  sel_type = T_BRK;
    else if (ovf_ok)    sel_type = T_OVF;
    else if (swint_req) sel_type = swint_type;
    else if (nmi_pend) begin
      sel_type = T_NMI;
      sel_nmi  = 1'b1;
    end
    else if (hw_ok)     sel_type = hw_type;
    else                any_src  = 1'b0;
  end

  assign hit = boundary && (st == S_IDLE) && any_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_s1   <= 1'b0;
      nmi_s2   <= 1'b0;
      nmi_s3   <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_s1   <= nmi_pin;
      nmi_s2   <= nmi_s1;
      nmi_s3   <= nmi_s2;
      nmi_pend <= (nmi_s2 & ~nmi_s3) | (nmi_pend & ~(hit & sel_nmi));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      type_q   <= '0;
      sv_flags <= '0;
      sv_cs    <= '0;
      sv_ip    <= '0;
      ip_tmp   <= '0;
      new_cs   <= '0;
      new_ip   <= '0;
      dma_q    <= 1'b0;
      flag_clr <= 1'b0;
      done     <= 1'b0;
    end else begin
      flag_clr <= (st == S_PF) && push_ack;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (hit) begin
          st       <= S_PF;
          type_q   <= sel_type;
          sv_flags <= flags_in;
          sv_cs    <= cs_in;
          sv_ip    <= ip_in;
          dma_q    <= sel_nmi;
        end
        S_PF: if (push_ack) st <= S_PC;
        S_PC: if (push_ack) st <= S_PI;
        S_PI: if (push_ack) st <= S_VI;
        S_VI: if (vec_ack) begin
          ip_tmp <= vec_data;
          st     <= S_VC;
        end
        S_VC: if (vec_ack) begin
          new_cs <= vec_data;
          new_ip <= ip_tmp;
          dma_q  <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign int_type    = type_q;
  assign dma_suspend = dma_q;
  assign vec_base    = {{PADW{1'b0}}, type_q, 2'b00};
  assign vec_addr    = {{PADW{1'b0}}, type_q, (st == S_VC), 1'b0};
  assign push_req    = (st == S_PF) || (st == S_PC) || (st == S_PI);
  assign vec_req     = (st == S_VI) || (st == S_VC);

  always_comb begin
    case (st)
      S_PF:    push_data = sv_flags;
      S_PC:    push_data = sv_cs;
      S_PI:    push_data = sv_ip;
      default: push_data = '0;
    endcase
  end
endmodule

// File: rtl/int_entry_chk.sv
module int_entry_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic [DW-1:0] push_data,
  input logic          push_ack,
  input logic          vec_req,
  input logic [AW-1:0] vec_addr,
  input logic          vec_ack,
  input logic          busy,
  input logic [TW-1:0] int_type,
  input logic [AW-1:0] vec_base,
  input logic          flag_clr,
  input logic          dma_suspend,
  input logic          done
);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req && vec_req));
  // R8
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ack |=> push_req && $stable(push_data));
  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req && !vec_ack |=> vec_req && $stable(vec_addr));
  // R1
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_addr[AW-1:2] == vec_base[AW-1:2]) && !vec_addr[0]
                && (vec_base[1:0] == 2'b00));
  // R10
  dma_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_suspend |-> busy && (int_type == TW'(8'h02)));
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> $past(push_req && push_ack) && push_req);
  // R11
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(vec_req && vec_ack));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !push_req && !vec_req && !dma_suspend);
endmodule

bind int_entry_seq int_entry_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
  .push_ack(push_ack), .vec_req(vec_req), .vec_addr(vec_addr),
  .vec_ack(vec_ack), .busy(busy), .int_type(int_type), .vec_base(vec_base),
  .flag_clr(flag_clr), .dma_suspend(dma_suspend), .done(done)
);

// File: tb/sim_int_entry_seq.sv
`timescale 1ns/1ps
module sim_int_entry_seq;
  logic clk = 0, rst_n = 0;
  logic boundary = 0, last_prefix = 0, last_segload = 0, last_wait = 0;
  logic tf_in = 0, if_in = 0, of_in = 0, div_err = 0, swint_req = 0;
  logic [7:0] swint_type = 0, hw_type = 0;
  logic int3_req = 0, into_req = 0, hw_req = 0, nmi_pin = 0;
  logic [15:0] flags_in = 0, cs_in = 0, ip_in = 0, vec_data = 0;
  logic push_ack = 0, vec_ack = 0;
  logic push_req, vec_req, busy, flag_clr, dma_suspend, done;
  logic [15:0] push_data, new_cs, new_ip;
  logic [19:0] vec_addr, vec_base;
  logic [7:0] int_type;

  int checks = 0, errors = 0, fc_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  int_entry_seq u0 (.*);

  always @(negedge clk) if (flag_clr) fc_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input bit tf, input bit pfx, input bit seg, input bit wt,
                      input bit dv, input bit sw, input logic [7:0] swt,
                      input bit i3, input bit ino, input bit ofl);
    @(negedge clk);
    tf_in = tf; last_prefix = pfx; last_segload = seg; last_wait = wt;
    div_err = dv; swint_req = sw; swint_type = swt; int3_req = i3;
    into_req = ino; of_in = ofl; boundary = 1;
    @(negedge clk);
    boundary = 0; div_err = 0; swint_req = 0; int3_req = 0; into_req = 0;
    last_prefix = 0; last_segload = 0; last_wait = 0;
  endtask

  task automatic do_push(input logic [15:0] exp, input int dly, input bit first, input string tag);
    int k = 0;
    while (!push_req && k < 20) begin @(negedge clk); k++; end
    chk(push_req == 1, {tag, " R8 push_req"}, push_req, 1);
    chk(push_data == exp, {tag, " R9 push_data"}, push_data, exp);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(push_req && push_data == exp, {tag, " R8 stall"}, push_data, exp);
      if (first) chk(flag_clr == 0, {tag, " R9 early clr"}, flag_clr, 0);
    end
    push_ack = 1;
    @(negedge clk);
    push_ack = 0;
    if (first) chk(flag_clr == 1, {tag, " R9 clr after flags"}, flag_clr, 1);
  endtask

  task automatic do_vec(input logic [19:0] exp_a, input logic [15:0] d, input int dly, input string tag);
    int k = 0;
    while (!vec_req && k < 20) begin @(negedge clk); k++; end
    chk(vec_req == 1 && push_req == 0, {tag, " R8 vec_req"}, vec_req, 1);
    chk(vec_addr == exp_a, {tag, " R1 vec_addr"}, vec_addr, exp_a);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(vec_req && vec_addr == exp_a, {tag, " R8 vec stall"}, vec_addr, exp_a);
    end
    vec_data = d; vec_ack = 1;
    @(negedge clk);
    vec_ack = 0;
  endtask

  task automatic entry(input logic [7:0] et, input bit is_nmi, input int dly, input string tag);
    logic [19:0] base = 20'(et) * 4;
    logic [15:0] fl = flags_in, cs = cs_in, ip = ip_in;
    int fc0 = fc_cnt;
    chk(busy == 1, {tag, " R2 busy"}, busy, 1);
    chk(int_type == et, {tag, " R2 type"}, int_type, et);
    chk(vec_base == base, {tag, " R1 base"}, vec_base, base);
    chk(dma_suspend == is_nmi, {tag, " R10 dma"}, dma_suspend, is_nmi);
    do_push(fl, dly, 1, tag);
    do_push(cs, dly, 0, tag);
    do_push(ip, dly, 0, tag);
    chk(dma_suspend == is_nmi, {tag, " R10 dma mid"}, dma_suspend, is_nmi);
    do_vec(base, {8'hA5, et}, dly, tag);
    do_vec(base + 2, {8'h5A, ~et}, dly, tag);
    chk(done == 1 && busy == 0, {tag, " R11 done"}, {done, busy}, 2);
    chk(new_ip == {8'hA5, et}, {tag, " R11 new_ip"}, new_ip, {8'hA5, et});
    chk(new_cs == {8'h5A, ~et}, {tag, " R11 new_cs"}, new_cs, {8'h5A, ~et});
    chk(dma_suspend == 0, {tag, " R10 dma end"}, dma_suspend, 0);
    chk(fc_cnt - fc0 == 1, {tag, " R9 clr count"}, fc_cnt - fc0, 1);
  endtask

  task automatic expect_none(input string tag);
    chk(busy == 0 && push_req == 0, {tag, " none"}, busy, 0);
    @(negedge clk);
    chk(busy == 0 && push_req == 0, {tag, " none+1"}, busy, 0);
  endtask

  task automatic nmi_edge();
    @(negedge clk); nmi_pin = 1;
    @(negedge clk); nmi_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !push_req && !vec_req && !dma_suspend && !flag_clr && !done,
        "R12 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !push_req && !vec_req && !dma_suspend, "R12 after reset", busy, 0);

    // R1 R4: all software types
    for (int t = 0; t < 256; t++) begin
      flags_in = 16'(t * 7); cs_in = 16'h1000 + 16'(t); ip_in = 16'h8000 ^ 16'(t);
      fire(0, 0, 0, 0, 0, 1, 8'(t), 0, 0, 0);
      entry(8'(t), 0, t % 3, "R4 swint");
    end
    // R5: all maskable types with IF set
    if_in = 1; hw_req = 1;
    for (int t = 0; t < 256; t++) begin
      hw_type = 8'(t); flags_in = 16'h0200 | 16'(t); cs_in = 16'(t); ip_in = ~16'(t);
      fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      entry(8'(t), 0, (t + 1) % 2, "R5 hw");
    end
    // R5: ignored with IF clear
    if_in = 0; hw_type = 8'h40;
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_none("R5 masked");
    // R4: INTO without OF ignored, with OF taken
    fire(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    expect_none("R4 into no ovf");
    fire(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    entry(8'h04, 0, 0, "R4 into ovf");
    fire(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    entry(8'h03, 0, 1, "R4 int3");
    fire(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    entry(8'h00, 0, 0, "R4 div");
    // R3: trace suppression over all qualifier combinations
    flags_in = 16'h0302;
    for (int c = 0; c < 16; c++) begin
      fire(c[3], c[2], c[1], c[0], 0, 0, 0, 0, 0, 0);
      if (c == 8) entry(8'h01, 0, 0, "R3 trace taken");
      else expect_none("R3 trace held");
    end
    // R2: priority ladder
    nmi_edge();
    if_in = 1; hw_type = 8'h77;
    fire(1, 0, 0, 0, 1, 1, 8'h21, 1, 1, 1); entry(8'h01, 0, 0, "R2 trace top");
    fire(0, 0, 0, 0, 1, 1, 8'h21, 1, 1, 1); entry(8'h00, 0, 0, "R2 div");
    fire(0, 0, 0, 0, 0, 1, 8'h21, 1, 1, 1); entry(8'h03, 0, 0, "R2 int3");
    fire(0, 0, 0, 0, 0, 1, 8'h21, 0, 1, 1); entry(8'h04, 0, 0, "R2 into");
    fire(0, 0, 0, 0, 0, 1, 8'h21, 0, 1, 0); entry(8'h21, 0, 0, "R2 swint");
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);     entry(8'h02, 1, 0, "R2 R6 nmi");
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);     entry(8'h77, 0, 0, "R2 hw last");
    hw_req = 0;
    // R6 R7: level held, re-edge during entry
    @(negedge clk); nmi_pin = 1;
    repeat (4) @(negedge clk);
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(dma_suspend == 1, "R10 nmi entry", dma_suspend, 1);
    nmi_pin = 0; @(negedge clk); nmi_pin = 1;
    entry(8'h02, 1, 3, "R7 nmi first");
    repeat (2) @(negedge clk);
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    entry(8'h02, 1, 0, "R7 nmi recaptured");
    repeat (2) @(negedge clk);
    fire(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_none("R6 level no retrigger");
    nmi_pin = 0;
    // R11: boundary during entry ignored
    fire(0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
    fire(0, 0, 0, 0, 0, 1, 8'h10, 0, 0, 0);
    entry(8'hFF, 0, 0, "R11 busy ignore R1 FFh");
    expect_none("R11 no queued");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule